// File: doc/BRIEF.md
# Conversion Command Queue Sequencer

This block is the digital controller in front of an analog-to-digital converter. It walks a shared command memory that holds two queues. Queue 1 always starts at index 0. Queue 2 starts at an index given on an input pin. For each command word the block selects the channel and then drives two timed sampling phases. After that it hands the conversion to the converter through a start/done handshake. The returned result is written into a result table at the same index as the command.

A scan starts on a per-queue trigger. In single-scan mode the queue must first be armed by a single-scan enable, and the block drops that enable when the scan finishes. In continuous mode the queue stays armed, and every trigger starts a new pass. A scan ends in one of three ways: a command whose channel code is 63, the start index of queue 2 (for queue 1 only), or the end of memory. A command can also carry a pause bit. After such a command has run, the queue waits for its next trigger before it goes on. Completion and pause flags are cleared by writing 1, and each flag has its own interrupt enable.

Command word layout: bits 5:0 hold the channel, bits 7:6 select the final-sample time, and bit 8 is the pause bit. The command memory is read combinationally at `cmd_addr_o`.

Top module: `cmd_queue_seq`

## Requirements
- R1: After reset, `busy_o`, every flag, every interrupt, `ss_en_o` and all phase strobes are 0.
- R2: In single-scan mode (`cont_mode_i[q]`=0), a trigger while `ss_en_o[q]`=0 is ignored: no scan starts and no result is written.
- R3: `ss_en_set_i[q]` sets `ss_en_o[q]`. The bit clears when queue q completes a scan.
- R4: In continuous mode (`cont_mode_i[q]`=1), every trigger while the block is idle starts a scan, without a single-scan enable.
- R5: Each command runs its stages in a fixed order: `samp_init_o` high for exactly 2 cycles, then `samp_final_o`, then a one-cycle `conv_start_o`.
- R6: `samp_final_o` lasts 2, 4, 8 or 16 cycles for command bits 7:6 = 0, 1, 2, 3.
- R7: When `conv_done_i` arrives, `conv_res_i` is written to `res_addr_o` equal to the index of the command that was converted.
- R8: After a command with bit 8 set has been converted, the block goes idle and sets `pause_flag_o[q]`. `pause_irq_o[q]` follows the flag when `pause_ie_i[q]`=1. The next trigger of that queue resumes at the following index.
- R9: A command with channel code 63 ends the queue, and no conversion is performed for it.
- R10: Queue 1 ends before index `q2_start_i`, and queue 2 starts at index `q2_start_i`.
- R11: Either queue ends after the last memory index (2**AW-1).
- R12: When a queue ends, `cmp_flag_o[q]` is set, and `cmp_irq_o[q]` follows it when `cmp_ie_i[q]`=1. Writing 1 to `cmp_clr_i[q]` or `pause_clr_i[q]` clears the matching flag.
- R13: When both queues are triggered in the same idle cycle, queue 1 runs and the queue 2 trigger is dropped. Triggers that arrive while a scan is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 2 | Trigger pulse for each queue |
| cont_mode_i | input | 2 | 1 = continuous mode, 0 = single-scan mode |
| ss_en_set_i | input | 2 | Pulse that arms single-scan |
| q2_start_i | input | AW | Start index of queue 2 |
| cmd_addr_o | output | AW | Command memory read index |
| cmd_data_i | input | 9 | Command word at that index |
| ch_o | output | 6 | Selected channel |
| samp_init_o | output | 1 | Initial sample phase |
| samp_final_o | output | 1 | Final sample phase |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_done_i | input | 1 | Conversion done pulse |
| conv_res_i | input | RES_W | Conversion result |
| res_we_o | output | 1 | Result table write strobe |
| res_addr_o | output | AW | Result table index |
| res_data_o | output | RES_W | Result table data |
| busy_o | output | 1 | A scan is executing |
| ss_en_o | output | 2 | Single-scan enable state |
| cmp_flag_o | output | 2 | Queue completion flags |
| pause_flag_o | output | 2 | Queue pause flags |
| cmp_clr_i | input | 2 | Write-1 clear of completion flags |
| pause_clr_i | input | 2 | Write-1 clear of pause flags |
| cmp_ie_i | input | 2 | Completion interrupt enables |
| pause_ie_i | input | 2 | Pause interrupt enables |
| cmp_irq_o | output | 2 | Completion interrupt requests |
| pause_irq_o | output | 2 | Pause interrupt requests |

## Verification
Some properties are checked on every cycle. Phases must follow one another in order. A conversion is never started for channel code 63. A scan only starts after a trigger. A pause flag rises right after a result write. A completion flag rises only as the block goes idle. The single-scan enable drops only together with completion.

Other behaviour only the bench scenarios can show. These are the exact phase lengths for each duration code and the result index and value. They also cover where each of the three end-of-queue rules lands and resuming after a pause at the next index. The scenarios also cover ignored triggers in single-scan mode, queue priority, and write-1 clearing.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int NQ     = 2;
  localparam int CH_W   = 6;
  localparam int CMD_W  = 9;
  localparam int CNT_W  = 5;
  localparam int INIT_CYC = 2;
  localparam logic [CH_W-1:0] CH_EOQ = 6'd63;

  typedef struct packed {
    logic            pause;
    logic [1:0]      fsel;
    logic [CH_W-1:0] ch;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_INIT, ST_FINAL, ST_REQ, ST_WAIT
  } st_e;
endpackage

// File: rtl/qseq_timer.sv
module qseq_timer
  import qseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/qseq_end_det.sv
module qseq_end_det
  import qseq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW:0]     idx_i,
  input  logic            q_sel_i,
  input  logic [AW-1:0]   q2_start_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            eoq_o
);
  logic past_top, q1_limit, code_end;

  assign past_top = idx_i[AW];
  assign q1_limit = !q_sel_i && (idx_i == {1'b0, q2_start_i});
  assign code_end = (ch_i == CH_EOQ);
  assign eoq_o    = past_top || q1_limit || code_end;
endmodule

// File: rtl/qseq_qstate.sv
module qseq_qstate #(
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ss_set_i,
  input  logic        start_i,
  input  logic        done_i,
  input  logic        pause_i,
  input  logic        cmp_clr_i,
  input  logic        pause_clr_i,
  input  logic [AW:0] next_idx_i,
  output logic        ss_en_o,
  output logic        cmp_flag_o,
  output logic        pause_flag_o,
  output logic        paused_o,
  output logic [AW:0] resume_idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_en_o      <= 1'b0;
      cmp_flag_o   <= 1'b0;
      pause_flag_o <= 1'b0;
      paused_o     <= 1'b0;
      resume_idx_o <= '0;
    end else begin
      if (ss_set_i)         ss_en_o <= 1'b1;
      else if (done_i)      ss_en_o <= 1'b0;
      if (done_i)           cmp_flag_o <= 1'b1;
      else if (cmp_clr_i)   cmp_flag_o <= 1'b0;
      if (pause_i)          pause_flag_o <= 1'b1;
      else if (pause_clr_i) pause_flag_o <= 1'b0;
      if (pause_i) begin
        paused_o     <= 1'b1;
        resume_idx_o <= next_idx_i;
      end else if (start_i) begin
        paused_o     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_queue_seq.sv
module cmd_queue_seq
  import qseq_pkg::*;
#(
  parameter int AW    = 4,
  parameter int RES_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NQ-1:0]     trig_i,
  input  logic [NQ-1:0]     cont_mode_i,
  input  logic [NQ-1:0]     ss_en_set_i,
  input  logic [AW-1:0]     q2_start_i,
  output logic [AW-1:0]     cmd_addr_o,
  input  logic [CMD_W-1:0]  cmd_data_i,
  output logic [CH_W-1:0]   ch_o,
  output logic              samp_init_o,
  output logic              samp_final_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_res_i,
  output logic              res_we_o,
  output logic [AW-1:0]     res_addr_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic              busy_o,
  output logic [NQ-1:0]     ss_en_o,
  output logic [NQ-1:0]     cmp_flag_o,
  output logic [NQ-1:0]     pause_flag_o,
  input  logic [NQ-1:0]     cmp_clr_i,
  input  logic [NQ-1:0]     pause_clr_i,
  input  logic [NQ-1:0]     cmp_ie_i,
  input  logic [NQ-1:0]     pause_ie_i,
  output logic [NQ-1:0]     cmp_irq_o,
  output logic [NQ-1:0]     pause_irq_o
);
  st_e         state_q;
  logic        act_q;
  logic [AW:0] idx_q, next_idx, start_idx;
  cmd_t        cmd_q, cur;

  logic [NQ-1:0] accept, start_p, done_p, pause_p, paused;
  logic [AW:0]   resume_idx [NQ];
  logic          start_any, start_q, eoq, tmr_zero, tmr_load, conv_ok;
  logic [CNT_W-1:0] tmr_val;

  assign cur      = cmd_t'(cmd_data_i);
  assign next_idx = idx_q + 1'b1;
  assign conv_ok  = (state_q == ST_WAIT) && conv_done_i;

  assign accept    = trig_i & (cont_mode_i | ss_en_o);
  assign start_any = |accept;
  assign start_q   = !accept[0];   // queue 1 wins a tie
  assign start_idx = paused[start_q] ? resume_idx[start_q]
                   : (start_q ? {1'b0, q2_start_i} : '0);

  qseq_end_det #(.AW(AW)) u_end (
    .idx_i      (idx_q),
    .q_sel_i    (act_q),
    .q2_start_i (q2_start_i),
    .ch_i       (cur.ch),
    .eoq_o      (eoq)
  );

  assign tmr_load = ((state_q == ST_FETCH) && !eoq) || ((state_q == ST_INIT) && tmr_zero);
  assign tmr_val  = (state_q == ST_FETCH) ? CNT_W'(INIT_CYC - 1)
                  : CNT_W'((CNT_W'(2) << cmd_q.fsel) - CNT_W'(1));

  qseq_timer u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign start_p[q] = (state_q == ST_IDLE) && start_any && (start_q == 1'(q));
    assign done_p[q]  = (state_q == ST_FETCH) && eoq && (act_q == 1'(q));
    assign pause_p[q] = conv_ok && cmd_q.pause && (act_q == 1'(q));

    qseq_qstate #(.AW(AW)) u_qs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ss_set_i     (ss_en_set_i[q]),
      .start_i      (start_p[q]),
      .done_i       (done_p[q]),
      .pause_i      (pause_p[q]),
      .cmp_clr_i    (cmp_clr_i[q]),
      .pause_clr_i  (pause_clr_i[q]),
      .next_idx_i   (next_idx),
      .ss_en_o      (ss_en_o[q]),
      .cmp_flag_o   (cmp_flag_o[q]),
      .pause_flag_o (pause_flag_o[q]),
      .paused_o     (paused[q]),
      .resume_idx_o (resume_idx[q])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      idx_q   <= '0;
      cmd_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_any) begin
          act_q   <= start_q;
          idx_q   <= start_idx;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          if (eoq) state_q <= ST_IDLE;
          else begin
            cmd_q   <= cur;
            state_q <= ST_INIT;
          end
        end
        ST_INIT:  if (tmr_zero) state_q <= ST_FINAL;
        ST_FINAL: if (tmr_zero) state_q <= ST_REQ;
        ST_REQ:   state_q <= ST_WAIT;
        ST_WAIT: if (conv_done_i) begin
          idx_q   <= next_idx;
          state_q <= cmd_q.pause ? ST_IDLE : ST_FETCH;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_addr_o   = idx_q[AW-1:0];
  assign ch_o         = cmd_q.ch;
  assign samp_init_o  = (state_q == ST_INIT);
  assign samp_final_o = (state_q == ST_FINAL);
  assign conv_start_o = (state_q == ST_REQ);
  assign res_we_o     = conv_ok;
  assign res_addr_o   = idx_q[AW-1:0];
  assign res_data_o   = conv_res_i;
  assign busy_o       = (state_q != ST_IDLE);
  assign cmp_irq_o    = cmp_flag_o & cmp_ie_i;
  assign pause_irq_o  = pause_flag_o & pause_ie_i;
endmodule

// File: rtl/cmd_queue_seq_chk.sv
module cmd_queue_seq_chk
  import qseq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NQ-1:0]   trig_i,
  input logic [CH_W-1:0] ch_o,
  input logic            samp_init_o,
  input logic            samp_final_o,
  input logic            conv_start_o,
  input logic            res_we_o,
  input logic            busy_o,
  input logic [NQ-1:0]   ss_en_o,
  input logic [NQ-1:0]   cmp_flag_o,
  input logic [NQ-1:0]   pause_flag_o
);
  // R5
  init_before_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(samp_final_o) |-> $past(samp_init_o));
  // R5
  final_before_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(samp_final_o));
  // R9
  no_eoq_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (ch_o != CH_EOQ));
  // R2
  start_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trig_i != '0));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    // R8
    pause_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pause_flag_o[q]) |-> $past(res_we_o));
    // R12
    cmp_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cmp_flag_o[q]) |-> !busy_o);
    // R3
    ss_drop_on_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ss_en_o[q]) |-> cmp_flag_o[q]);
  end
endmodule

bind cmd_queue_seq cmd_queue_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_i),
  .ch_o         (ch_o),
  .samp_init_o  (samp_init_o),
  .samp_final_o (samp_final_o),
  .conv_start_o (conv_start_o),
  .res_we_o     (res_we_o),
  .busy_o       (busy_o),
  .ss_en_o      (ss_en_o),
  .cmp_flag_o   (cmp_flag_o),
  .pause_flag_o (pause_flag_o)
);

// File: tb/cmd_queue_seq_bench.sv
`timescale 1ns/1ps
module cmd_queue_seq_bench;
  localparam int AW = 4;
  localparam int RES_W = 10;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] trig_i = '0, cont_mode_i = '0, ss_en_set_i = '0;
  logic [AW-1:0] q2_start_i = AW'(8);
  logic [AW-1:0] cmd_addr_o;
  logic [8:0] cmd_data_i;
  logic [5:0] ch_o;
  logic samp_init_o, samp_final_o, conv_start_o, res_we_o, busy_o;
  logic conv_done_i = 1'b0;
  logic [RES_W-1:0] conv_res_i = '0;
  logic [AW-1:0] res_addr_o;
  logic [RES_W-1:0] res_data_o;
  logic [1:0] ss_en_o, cmp_flag_o, pause_flag_o, cmp_irq_o, pause_irq_o;
  logic [1:0] cmp_clr_i = '0, pause_clr_i = '0, cmp_ie_i = '0, pause_ie_i = '0;

  logic [8:0] cmd_mem [DEPTH];
  assign cmd_data_i = cmd_mem[cmd_addr_o];

  always #2.5 clk_i = ~clk_i;

  cmd_queue_seq #(.AW(AW), .RES_W(RES_W)) u_cmd_queue_seq (.*);

  // converter stub: done 3 cycles after start, result = {A, channel}
  int dly = 0;
  always @(negedge clk_i) begin
    conv_done_i <= 1'b0;
    if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        conv_done_i <= 1'b1;
        conv_res_i  <= {4'hA, ch_o};
      end
    end else if (conv_start_o) dly <= 3;
  end

  // monitor
  int n_init = 0, n_fin = 0, n_wr = 0;
  logic [AW-1:0] last_addr = '0;
  logic [RES_W-1:0] last_data = '0;
  logic [RES_W-1:0] res_tab [DEPTH];
  always @(posedge clk_i) if (rst_ni) begin
    if (samp_init_o)  n_init <= n_init + 1;
    if (samp_final_o) n_fin  <= n_fin + 1;
    if (res_we_o) begin
      n_wr <= n_wr + 1;
      last_addr <= res_addr_o;
      last_data <= res_data_o;
      res_tab[res_addr_o] <= res_data_o;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] mk(input logic p, input logic [1:0] f, input logic [5:0] c);
    return {p, f, c};
  endfunction

  task automatic fill_eoq();
    for (int i = 0; i < DEPTH; i++) cmd_mem[i] = mk(1'b0, 2'd0, 6'd63);
  endtask

  task automatic run(input logic [1:0] m);
    @(negedge clk_i); trig_i = m;
    @(negedge clk_i); trig_i = '0;
    for (int i = 0; i < 500 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic arm(input logic [1:0] m);
    @(negedge clk_i); ss_en_set_i = m;
    @(negedge clk_i); ss_en_set_i = '0;
  endtask

  task automatic clr_all();
    @(negedge clk_i); cmp_clr_i = '1; pause_clr_i = '1;
    @(negedge clk_i); cmp_clr_i = '0; pause_clr_i = '0;
  endtask

  // {fsel, channel, expected final-sample cycles}
  localparam logic [12:0] VEC [4] = '{
    {2'd0, 6'd11, 5'd2}, {2'd1, 6'd12, 5'd4},
    {2'd2, 6'd13, 5'd8}, {2'd3, 6'd14, 5'd16}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    int w0, i0, f0;
    fill_eoq();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({busy_o, samp_init_o, samp_final_o, conv_start_o} == 4'b0, "R1 idle/strobes",
        {busy_o, samp_init_o, samp_final_o, conv_start_o}, 0);
    chk({ss_en_o, cmp_flag_o, pause_flag_o, cmp_irq_o, pause_irq_o} == '0, "R1 flags",
        {ss_en_o, cmp_flag_o, pause_flag_o, cmp_irq_o, pause_irq_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // vector table: one command, R5 R6 R7 R9 R3 R12
    foreach (VEC[k]) begin
      fill_eoq();
      cmd_mem[0] = mk(1'b0, VEC[k][12:11], VEC[k][10:5]);
      clr_all();
      arm(2'b01);
      w0 = n_wr; i0 = n_init; f0 = n_fin;
      run(2'b01);
      chk(n_init - i0 == 2, "R5 init length", n_init - i0, 2);
      chk(n_fin - f0 == int'(VEC[k][4:0]), "R6 final length", n_fin - f0, int'(VEC[k][4:0]));
      chk(n_wr - w0 == 1, "R9 single conversion", n_wr - w0, 1);
      chk(last_addr == 0 && last_data == {4'hA, VEC[k][10:5]}, "R7 result",
          {last_addr, last_data}, {4'h0, 4'hA, VEC[k][10:5]});
      chk(cmp_flag_o[0] && !ss_en_o[0], "R3 R12 done clears enable",
          {cmp_flag_o[0], ss_en_o[0]}, 2'b10);
    end

    // R2: single-scan without enable ignored
    clr_all();
    fill_eoq(); cmd_mem[0] = mk(1'b0, 2'd0, 6'd3);
    w0 = n_wr;
    @(negedge clk_i); trig_i = 2'b01;
    @(negedge clk_i); trig_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && n_wr == w0 && !cmp_flag_o[0], "R2 ignored trigger",
        {busy_o, cmp_flag_o[0]}, 0);

    // R9: first command is end code
    fill_eoq();
    arm(2'b01); w0 = n_wr;
    run(2'b01);
    chk(n_wr == w0 && cmp_flag_o[0], "R9 empty queue", n_wr - w0, 0);

    // R8 pause and resume
    clr_all();
    fill_eoq();
    cmd_mem[0] = mk(1'b1, 2'd0, 6'd5);
    cmd_mem[1] = mk(1'b0, 2'd0, 6'd6);
    pause_ie_i = 2'b01;
    arm(2'b01); w0 = n_wr;
    run(2'b01);
    chk(n_wr - w0 == 1 && last_data == 10'h285, "R8 stop after paused cmd", last_data, 10'h285);
    chk(pause_flag_o[0] && pause_irq_o[0] && !cmp_flag_o[0], "R8 pause flag/irq",
        {pause_flag_o[0], pause_irq_o[0], cmp_flag_o[0]}, 3'b110);
    run(2'b01);
    chk(n_wr - w0 == 2 && last_addr == 1 && last_data == 10'h286, "R8 resume next index",
        {last_addr, last_data}, {4'h1, 10'h286});
    chk(cmp_flag_o[0] == 1'b1, "R8 completes after resume", cmp_flag_o[0], 1);
    pause_ie_i = '0;

    // R12 interrupt and write-1 clear
    cmp_ie_i = 2'b01;
    @(negedge clk_i);
    chk(cmp_irq_o[0] == 1'b1, "R12 completion irq", cmp_irq_o[0], 1);
    clr_all();
    chk(cmp_flag_o == 0 && pause_flag_o == 0 && cmp_irq_o == 0, "R12 write-1 clear",
        {cmp_flag_o, pause_flag_o}, 0);
    cmp_ie_i = '0;

    // R10 queue boundary at q2 start
    fill_eoq();
    q2_start_i = AW'(3);
    for (int i = 0; i < 4; i++) cmd_mem[i] = mk(1'b0, 2'd0, 6'(20 + i));
    arm(2'b11); w0 = n_wr;
    run(2'b01);
    chk(n_wr - w0 == 3 && last_addr == 2, "R10 queue 1 stops before q2 start",
        n_wr - w0, 3);
    run(2'b10);
    chk(n_wr - w0 == 4 && last_addr == 3 && res_tab[3] == 10'h297 && cmp_flag_o[1],
        "R10 queue 2 starts at pointer", {last_addr, res_tab[3]}, {4'h3, 10'h297});

    // R11 top of memory
    clr_all();
    fill_eoq();
    q2_start_i = AW'(12);
    for (int i = 12; i < DEPTH; i++) cmd_mem[i] = mk(1'b0, 2'd0, 6'(30 + i));
    arm(2'b10); w0 = n_wr;
    run(2'b10);
    chk(n_wr - w0 == 4 && last_addr == 4'hF && cmp_flag_o[1], "R11 ends at top",
        {n_wr - w0, last_addr}, {4, 4'hF});

    // R4 continuous: rescans without enable
    clr_all();
    fill_eoq();
    q2_start_i = AW'(8);
    cmd_mem[0] = mk(1'b0, 2'd0, 6'd9);
    cmd_mem[8] = mk(1'b0, 2'd0, 6'd10);
    cont_mode_i = 2'b11; w0 = n_wr;
    run(2'b01);
    run(2'b01);
    chk(n_wr - w0 == 2 && cmp_flag_o[0], "R4 continuous rescans", n_wr - w0, 2);

    // R13 tie goes to queue 1
    clr_all(); w0 = n_wr;
    run(2'b11);
    chk(n_wr - w0 == 1 && last_addr == 0 && cmp_flag_o == 2'b01, "R13 queue 1 priority",
        {last_addr, cmp_flag_o}, 6'b000001);

    // R13 trigger while busy ignored
    clr_all(); w0 = n_wr;
    @(negedge clk_i); trig_i = 2'b01;
    @(negedge clk_i); trig_i = 2'b00;
    @(negedge clk_i); trig_i = 2'b10;
    @(negedge clk_i); trig_i = 2'b00;
    for (int i = 0; i < 500 && busy_o; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    chk(n_wr - w0 == 1 && cmp_flag_o == 2'b01, "R13 busy trigger dropped",
        cmp_flag_o, 2'b01);

    finished = 1;
    summary();
    $finish;
  end
endmodule